// File: doc/BRIEF.md
# Scaled-Counter Four-Channel PWM Timer

This block generates four pulse-width-modulated outputs from a single free-running counter. Software programs a power-of-two scale that selects which 16-bit slice of the counter drives the comparators. The scale is the only control over the period length: one period lasts 2^(16+scale) clock ticks. Each channel has its own 16-bit compare value.

Each output pin is driven low while the scaled count is at or above the channel's compare value, and high below it. The output is therefore inverted with respect to the compare value. A compare of zero keeps the pin permanently low. No compare value can keep the pin high for a whole period.

Software reaches the configuration, the raw counter, the scaled counter view and the four compare registers over a simple register bus. Writes are single-cycle. Reads are combinational from the current state.

Top module: `scaled_pwm`

## Requirements
- R1: Reset clears the scale, the run bit, the counter and all four compare registers. The counter then stays at zero and every pin is low.
- R2: Offset 0x00 holds the configuration. The scale occupies bits 3:0 and the run bit is bit 12. All other bits read as zero. Reads from offsets that no register decodes return zero.
- R3: While the run bit is set, the counter at offset 0x08 rises by one on every clock. While the bit is clear, the counter holds its value.
- R4: A write to offset 0x08 loads bits 30:0 of the write data into the counter. This load takes precedence over the increment in the same cycle.
- R5: Offset 0x10 reads as the 16 bits of the counter shifted right by the scale. Writes to this offset change nothing.
- R6: Once the counter has reached 2^(16+scale)-1, the next increment returns it to zero.
- R7: Compare register n (n = 0..3) sits at offset 0x20+4n. It stores 16 bits, and its upper bits read as zero.
- R8: Pin n is low while the scaled count is greater than or equal to compare n, and high otherwise. A compare of 0 holds the pin low at all times.
- R9: Over one full period at scale 0, pin n is high for exactly compare-n ticks. With a compare of 0xFFFF the pin is still low for one tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_out | output | 4 | Inverted PWM pins, one per channel |

## Verification
The bench drives the counter to the top of the selected window at scales 0, 1 and 15 and checks that it returns to zero. A wrong wrap mask would instead run on past the period or wrap too early. It checks the scaled view at large scales, where an off-by-one shift would halve or double the value read back. It also counts high ticks over a full period for compares of 0, 0x4000, 0x8000 and 0xFFFF. A comparator using the wrong inequality would miscount by one tick or allow a 100% duty cycle. Finally, it writes to the read-only scaled offset and loads the counter while it runs, which catches ignored-write leaks and lost loads.

// File: rtl/scaled_pwm.sv
module scaled_pwm #(
  parameter int CHANNELS = 4,
  parameter int CMP_W    = 16,
  parameter int SCALE_W  = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int RUN_BIT  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [CHANNELS-1:0] pwm_out
);
  localparam int MAX_SCALE = (1 << SCALE_W) - 1;
  localparam int CNT_W     = CMP_W + MAX_SCALE;
  localparam logic [ADDR_W-1:0] OFS_CFG = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_CNT = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_SCL = ADDR_W'(8'h10);
  localparam int CMP_BASE = 'h20;

  logic [SCALE_W-1:0]            scale;
  logic                          run;
  logic [CNT_W-1:0]              cnt;
  logic [CHANNELS-1:0][CMP_W-1:0] cmp;
  logic [CNT_W-1:0]              wrap_mask;
  logic [CMP_W-1:0]              scaled;

  wire wr_cfg = bus_wr && (bus_addr == OFS_CFG);
  wire wr_cnt = bus_wr && (bus_addr == OFS_CNT);

  assign wrap_mask = {CNT_W{1'b1}} >> (SCALE_W'(MAX_SCALE) - scale);
  assign scaled    = CMP_W'(cnt >> scale);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale <= '0;
      run   <= 1'b0;
    end else if (wr_cfg) begin
      scale <= bus_wdata[SCALE_W-1:0];
      run   <= bus_wdata[RUN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_cnt) cnt <= bus_wdata[CNT_W-1:0];
    else if (run)    cnt <= (cnt + 1'b1) & wrap_mask;
  end

  for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CMP_BASE + 4 * i);
    always_ff @(posedge clk) begin
      if (!rst_n)                          cmp[i] <= '0;
      else if (bus_wr && bus_addr == OFS)  cmp[i] <= bus_wdata[CMP_W-1:0];
    end
    assign pwm_out[i] = scaled < cmp[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CFG) begin
      bus_rdata[SCALE_W-1:0] = scale;
      bus_rdata[RUN_BIT]     = run;
    end else if (bus_addr == OFS_CNT) begin
      bus_rdata[CNT_W-1:0] = cnt;
    end else if (bus_addr == OFS_SCL) begin
      bus_rdata[CMP_W-1:0] = scaled;
    end else begin
      for (int i = 0; i < CHANNELS; i++)
        if (bus_addr == ADDR_W'(CMP_BASE + 4 * i)) bus_rdata[CMP_W-1:0] = cmp[i];
    end
  end
endmodule

// File: rtl/scaled_pwm_sva.sv
module scaled_pwm_sva #(
  parameter int CHANNELS = 4,
  parameter int CMP_W    = 16,
  parameter int SCALE_W  = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 31
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_wr,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic                       run,
  input logic [SCALE_W-1:0]         scale,
  input logic [CNT_W-1:0]           cnt,
  input logic [CHANNELS-1:0][CMP_W-1:0] cmp,
  input logic [CHANNELS-1:0]        pwm_out
);
  logic [CNT_W-1:0] top_val;
  assign top_val = CNT_W'((64'h1 << (CMP_W + int'(scale))) - 64'h1);
  wire ld = bus_wr && bus_addr == ADDR_W'(8'h08);

  a_r1_reset_clear: assert property (@(posedge clk) $rose(rst_n) |-> cnt == '0 && !run);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !ld |=> $stable(cnt));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    run && !ld && cnt < top_val |=> cnt == $past(cnt) + 1'b1);

  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    run && !ld && cnt == top_val |=> cnt == '0);

  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(bus_wdata[CNT_W-1:0]));

  for (genvar i = 0; i < CHANNELS; i++) begin : g_chk
    a_r8_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      cmp[i] == '0 |-> !pwm_out[i]);
  end
endmodule

bind scaled_pwm scaled_pwm_sva #(
  .CHANNELS(CHANNELS), .CMP_W(CMP_W), .SCALE_W(SCALE_W),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .run(run), .scale(scale), .cnt(cnt),
  .cmp(cmp), .pwm_out(pwm_out)
);

// File: tb/scaled_pwm_test.sv
module scaled_pwm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [31:0] RUN = 32'h0000_1000;

  scaled_pwm uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); check("R1 cfg", d, 0);
    rd(8'h08, d); check("R1 cnt", d, 0);
    for (int i = 0; i < 4; i++) begin rd(8'h20 + 8'(4*i), d); check("R1 cmp", d, 0); end
    @(negedge clk); rd(8'h08, d); check("R1 stopped", d, 0);
    check("R1 pins", 32'(pwm_out), 0);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R2 cfg bits", d, 32'h0000_100F);
    wr(8'h00, 32'h0000_0005);
    rd(8'h00, d); check("R2 scale only", d, 32'h5);
    rd(8'h04, d); check("R2 unmapped", d, 0);
    rd(8'h30, d); check("R2 unmapped hi", d, 0);
  endtask

  task automatic t_count;
    logic [31:0] d, e;
    wr(8'h00, RUN);
    wr(8'h08, 32'd100);
    rd(8'h08, d); check("R4 load while running", d, 100);
    @(negedge clk); rd(8'h08, d); check("R3 step", d, 101);
    @(negedge clk); rd(8'h08, d); check("R3 step2", d, 102);
    wr(8'h00, 32'h0);
    rd(8'h08, e);
    @(negedge clk); @(negedge clk); rd(8'h08, d); check("R3 hold", d, e);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); check("R4 31 bits", d, 32'h7FFF_FFFF);
  endtask

  task automatic t_scaled;
    logic [31:0] d;
    wr(8'h00, 32'h4);
    wr(8'h08, 32'h0001_2345);
    rd(8'h10, d); check("R5 scale4", d, 32'h1234);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h08, d); check("R5 write ignored cnt", d, 32'h0001_2345);
    rd(8'h10, d); check("R5 write ignored view", d, 32'h1234);
    wr(8'h00, 32'hF);
    wr(8'h08, 32'h7FFF_0000);
    rd(8'h10, d); check("R5 scale15", d, 32'hFFFE);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    wr(8'h00, RUN | 32'h0);
    wr(8'h08, 32'h0000_FFFF);
    @(negedge clk); rd(8'h08, d); check("R6 wrap s0", d, 0);
    wr(8'h00, RUN | 32'h1);
    wr(8'h08, 32'h0000_FFFF);
    @(negedge clk); rd(8'h08, d); check("R6 no wrap s1", d, 32'h0001_0000);
    wr(8'h08, 32'h0001_FFFF);
    @(negedge clk); rd(8'h08, d); check("R6 wrap s1", d, 0);
    wr(8'h00, RUN | 32'hF);
    wr(8'h08, 32'h7FFF_FFFF);
    @(negedge clk); rd(8'h08, d); check("R6 wrap s15", d, 0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_cmp_regs;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) wr(8'h20 + 8'(4*i), 32'hABC0_0000 | 32'(16'h1110 * (i+1)));
    for (int i = 0; i < 4; i++) begin
      rd(8'h20 + 8'(4*i), d); check("R7 cmp readback", d, 32'(16'h1110 * (i+1)));
    end
  endtask

  task automatic t_pins;
    wr(8'h00, 32'h0);
    wr(8'h20, 32'd3); wr(8'h24, 32'd0); wr(8'h28, 32'hFFFF); wr(8'h2C, 32'h1);
    wr(8'h08, 32'd0);  #1 check("R8 below cmp", 32'(pwm_out), 32'b1101);
    wr(8'h08, 32'd3);  #1 check("R8 at cmp", 32'(pwm_out), 32'b0100);
    wr(8'h08, 32'hFFFF); #1 check("R9 ffff top", 32'(pwm_out), 32'b0000);
    wr(8'h00, 32'h2);
    wr(8'h08, 32'hB);  #1 check("R8 scale2 below", 32'(pwm_out), 32'b0101);
    wr(8'h08, 32'hC);  #1 check("R8 scale2 at", 32'(pwm_out), 32'b0100);
  endtask

  task automatic t_duty;
    int hi [4];
    wr(8'h00, 32'h0);
    wr(8'h20, 32'h8000); wr(8'h24, 32'h0); wr(8'h28, 32'hFFFF); wr(8'h2C, 32'h4000);
    wr(8'h08, 32'h0);
    wr(8'h00, RUN);
    for (int i = 0; i < 4; i++) hi[i] = 0;
    for (int k = 0; k < 65536; k++) begin
      #1;
      for (int i = 0; i < 4; i++) if (pwm_out[i]) hi[i]++;
      @(negedge clk);
    end
    check("R9 duty 8000", 32'(hi[0]), 32'h8000);
    check("R8 duty zero", 32'(hi[1]), 0);
    check("R9 duty ffff", 32'(hi[2]), 32'hFFFF);
    check("R9 duty 4000", 32'(hi[3]), 32'h4000);
    wr(8'h00, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg();
    t_count();
    t_scaled();
    t_wrap();
    t_cmp_regs();
    t_pins();
    t_duty();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule